// File: doc/BRIEF.md
# Dual Up/Down Event Counter

This block keeps two independent 16-bit event counters driven from a single 8-bit input port. The port pins are asynchronous to the block clock, so they first pass through a two-stage synchroniser. The synchronised port is examined only when a periodic tick strobe is high. The tick comes from outside the block, and its nominal period is a few milliseconds. On each tick, every counter compares its clock bit against the value stored at the previous tick. A rising edge between the two samples moves the counter one step, either up or down according to its direction bit. A reset bit that is high on a tick clears the counter, and this overrides any count.

A host can load any 16-bit value into either counter through a small write port. Both counter values are always visible on one 32-bit read vector. Typical uses are position or event counting on slow mechanical or logic signals, where a millisecond-scale sampling rate is enough.

Top module: `dual_event_counter`

## Requirements
- R1: After a synchronous active-low reset, both counters read zero and the stored previous samples are zero.
- R2: A change on `port_in` that is driven just after one rising clock edge is seen first by a tick sampled at the third rising edge after it. Ticks at the first and second edges still see the old port value.
- R3: A counter moves only on a tick whose sampled clock bit is 1 while the clock bit stored at the previous tick is 0. A clock bit held high over several ticks gives one count, and a pulse that starts and ends between two ticks gives none.
- R4: A direction bit of 1 adds one and a direction bit of 0 subtracts one. The count wraps modulo 65536, so 0x0000 minus one is 0xFFFF and 0xFFFF plus one is 0x0000.
- R5: Counter 0 takes its clock from port bit 0, its direction from bit 1 and its reset from bit 2. Counter 1 takes its clock from bit 4, its direction from bit 5 and its reset from bit 6. Bits 3 and 7 have no effect on either counter.
- R6: If a counter's reset bit is 1 on a tick, the counter becomes zero whatever its clock bit does. The stored previous clock sample is still updated on that tick, so a clock bit that rose during reset is not counted once reset is released.
- R7: When `ld_en` is 1, `ld_val` is written into the counter chosen by `ld_sel` (0 selects counter 0, 1 selects counter 1). The value appears on the next cycle. A load wins over a tick event for the same counter in the same cycle, and the previous sample is still updated by that tick.
- R8: `cnt_out[15:0]` carries counter 0 and `cnt_out[31:16]` carries counter 1.
- R9: In a cycle with neither a tick nor a load, neither counter changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_in | input | 8 | Asynchronous input pins (clock, direction and reset bits for both counters) |
| tick | input | 1 | One-cycle sampling strobe |
| ld_en | input | 1 | Host load strobe |
| ld_sel | input | 1 | Counter index for a load |
| ld_val | input | 16 | Value to load |
| cnt_out | output | 32 | Both counter values, counter 0 in the low half |

## Verification
The bound checker keeps its own record of the clock bits at each tick. Using that record, it checks on every cycle that a counter holds when there is neither tick nor load, that a load lands exactly, and that a reset bit clears the counter. It also checks that a qualifying edge moves the counter exactly one step in the direction its bit selects, and that a tick without an edge leaves the counter alone. Some behaviours can only be shown by the bench's directed scenarios, because they depend on a sequence of inputs: the two-edge synchroniser latency, and the ignoring of a pulse that starts and ends between ticks. The same holds for wrap at both ends, for the inert port bits, and for edges that were suppressed by reset and stay uncounted after release.

// File: rtl/evcnt_pkg.sv
`timescale 1ns/1ps
// Shared parameters for the dual event counter.
// Each counter owns one field of FIELD_W bits within the port. Inside that
// field, the offsets below pick out the clock, direction and reset bits.
package evcnt_pkg;
    localparam int PORT_W  = 8;
    localparam int CNT_W   = 16;
    localparam int NUM_CNT = 2;
    localparam int FIELD_W = 4;
    localparam int CLK_OFS = 0;
    localparam int DIR_OFS = 1;
    localparam int RST_OFS = 2;

    // Port bit position of a given role for counter idx.
    function automatic int bit_pos(input int idx, input int ofs);
        return idx * FIELD_W + ofs;
    endfunction

    // Mask of every port bit that some counter reads.
    function automatic logic [PORT_W-1:0] used_mask();
        logic [PORT_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            m[bit_pos(i, CLK_OFS)] = 1'b1;
            m[bit_pos(i, DIR_OFS)] = 1'b1;
            m[bit_pos(i, RST_OFS)] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/evcnt_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for an asynchronous input bus.
// Assumes each bit is slow relative to clk. Bits are synchronised
// independently, and no bus coherency is promised.
module evcnt_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: shift the bus one stage further into the clock domain.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage_q[s] <= '0;
                else if (s == 0)
                    stage_q[s] <= d_async;
                else
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/evcnt_unit.sv
`timescale 1ns/1ps
// One up/down event counter driven by tick-spaced samples.
// Assumes that the inputs are already synchronous and that tick is a one-cycle strobe.
// Priority: a host load first, then a reset bit on a tick, then an edge count.
module evcnt_unit #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clk_bit,
    input  logic             dir_bit,
    input  logic             rst_bit,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count
);
    logic prev_clk;
    logic rise;

    assign rise = tick & clk_bit & ~prev_clk;

    // Purpose: remember the clock bit seen at the latest tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_clk <= 1'b0;
        else if (tick)
            prev_clk <= clk_bit;
    end

    // Purpose: update the count by load, reset or a single step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (tick && rst_bit)
            count <= '0;
        else if (rise)
            count <= dir_bit ? count + CNT_W'(1) : count - CNT_W'(1);
    end
endmodule

// File: rtl/dual_event_counter.sv
`timescale 1ns/1ps
// Dual up/down event counter on a shared, tick-sampled input port.
// Assumes tick is a single-cycle strobe from an external timebase and that
// port_in is asynchronous. Port bit roles come from evcnt_pkg.
module dual_event_counter
    import evcnt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PORT_W-1:0]        port_in,
    input  logic                     tick,
    input  logic                     ld_en,
    input  logic                     ld_sel,
    input  logic [CNT_W-1:0]         ld_val,
    output logic [NUM_CNT*CNT_W-1:0] cnt_out
);
    localparam logic [PORT_W-1:0] USED = used_mask();

    logic [PORT_W-1:0] port_s;
    logic [PORT_W-1:0] port_unused_bits;

    assign port_unused_bits = port_s & ~USED;

    evcnt_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (port_in),
        .q_sync  (port_s)
    );

    genvar i;
    generate
        for (i = 0; i < NUM_CNT; i++) begin : g_cnt
            logic             hit;
            logic [CNT_W-1:0] value;

            assign hit = ld_en && (ld_sel == 1'(i));

            evcnt_unit #(.CNT_W(CNT_W)) i_unit (
                .clk      (clk),
                .rst_n    (rst_n),
                .tick     (tick),
                .clk_bit  (port_s[bit_pos(i, CLK_OFS)]),
                .dir_bit  (port_s[bit_pos(i, DIR_OFS)]),
                .rst_bit  (port_s[bit_pos(i, RST_OFS)]),
                .load     (hit),
                .load_val (ld_val),
                .count    (value)
            );

            assign cnt_out[i*CNT_W +: CNT_W] = value;
        end
    endgenerate
endmodule

// File: rtl/dual_event_counter_chk.sv
`timescale 1ns/1ps
// Property checker for dual_event_counter. It keeps its own record of the
// clock bits at each tick and checks how each counter moves.
module dual_event_counter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        ld_en,
    input logic        ld_sel,
    input logic [15:0] ld_val,
    input logic        c0_clk,
    input logic        c0_dir,
    input logic        c0_rst,
    input logic        c1_clk,
    input logic        c1_rst,
    input logic [31:0] cnt_out
);
    logic seen0, seen1;

    // Purpose: clock bits recorded at the last tick, kept independently of the design.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen0 <= 1'b0;
            seen1 <= 1'b0;
        end else if (tick) begin
            seen0 <= c0_clk;
            seen1 <= c1_clk;
        end
    end

    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ld_en) |=> $stable(cnt_out));

    p_load_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> ((ld_sel ? cnt_out[31:16] : cnt_out[15:0]) == $past(ld_val)));

    p_clear0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && c0_rst && !(ld_en && !ld_sel)) |=> (cnt_out[15:0] == 16'h0000));

    p_clear1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && c1_rst && !(ld_en && ld_sel)) |=> (cnt_out[31:16] == 16'h0000));

    p_step_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld_en && !c0_rst && c0_clk && !seen0 && c0_dir)
        |=> (cnt_out[15:0] == $past(cnt_out[15:0]) + 16'd1));

    p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld_en && !c0_rst && c0_clk && !seen0 && !c0_dir)
        |=> (cnt_out[15:0] == $past(cnt_out[15:0]) - 16'd1));

    p_no_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld_en && !c0_rst && !(c0_clk && !seen0))
        |=> $stable(cnt_out[15:0]));

    p_no_edge1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld_en && !c1_rst && !(c1_clk && !seen1))
        |=> $stable(cnt_out[31:16]));
endmodule

bind dual_event_counter dual_event_counter_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .ld_en   (ld_en),
    .ld_sel  (ld_sel),
    .ld_val  (ld_val),
    .c0_clk  (port_s[0]),
    .c0_dir  (port_s[1]),
    .c0_rst  (port_s[2]),
    .c1_clk  (port_s[4]),
    .c1_rst  (port_s[6]),
    .cnt_out (cnt_out)
);

// File: tb/test_dual_event_counter.sv
`timescale 1ns/1ps
// Directed bench for dual_event_counter: one task per scenario.
module test_dual_event_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  port_in = 8'h00;
    logic        tick = 1'b0;
    logic        ld_en = 1'b0;
    logic        ld_sel = 1'b0;
    logic [15:0] ld_val = 16'h0000;
    logic [31:0] cnt_out;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dual_event_counter i_dual_event_counter (
        .clk(clk), .rst_n(rst_n), .port_in(port_in), .tick(tick),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_val(ld_val), .cnt_out(cnt_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Drive the port and wait until the synchroniser has passed it through.
    task automatic settle(input logic [7:0] v);
        @(negedge clk);
        port_in = v;
        repeat (3) @(negedge clk);
    endtask

    // One tick; returns at the negedge after the sampling edge.
    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic load(input logic sel, input logic [15:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = sel; ld_val = v;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic set_port_tick(input logic [7:0] v);
        settle(v);
        pulse_tick();
    endtask

    task automatic t_reset();
        check("R1 reset value", cnt_out, 32'h0);
        set_port_tick(8'h00);
        check("R1 reset value after idle tick", cnt_out, 32'h0);
    endtask

    task automatic t_count_up();
        load(0, 16'h0000); load(1, 16'h0000);
        set_port_tick(8'h02);
        set_port_tick(8'h03);
        check("R3 R4 rising edge counts up", cnt_out, 32'h0000_0001);
        set_port_tick(8'h03);
        check("R3 held high no extra count", cnt_out, 32'h0000_0001);
        set_port_tick(8'h02);
        set_port_tick(8'h03);
        check("R3 second edge", cnt_out, 32'h0000_0002);
        // pulse between ticks: 0 -> 1 -> 0 with no tick while high
        set_port_tick(8'h02);
        settle(8'h03);
        settle(8'h02);
        pulse_tick();
        check("R3 inter-tick pulse ignored", cnt_out, 32'h0000_0002);
    endtask

    task automatic t_count_down_wrap();
        load(0, 16'h0001); load(1, 16'h0000);
        set_port_tick(8'h00);
        set_port_tick(8'h01);
        check("R4 count down", cnt_out, 32'h0000_0000);
        set_port_tick(8'h00);
        set_port_tick(8'h01);
        check("R4 wrap below zero", cnt_out, 32'h0000_FFFF);
        set_port_tick(8'h02);
        set_port_tick(8'h03);
        check("R4 wrap above max", cnt_out, 32'h0000_0000);
    endtask

    task automatic t_second_counter();
        load(0, 16'h0010); load(1, 16'h0000);
        set_port_tick(8'h20);
        set_port_tick(8'h30);
        check("R5 R8 counter 1 up in high half", cnt_out, 32'h0001_0010);
        set_port_tick(8'h00);
        set_port_tick(8'h10);
        check("R5 counter 1 down", cnt_out, 32'h0000_0010);
        set_port_tick(8'h50);
        check("R5 counter 1 reset bit 6", cnt_out, 32'h0000_0010);
        load(1, 16'h0042);
        set_port_tick(8'h40);
        check("R5 bit 6 clears counter 1 only", cnt_out, 32'h0000_0010);
    endtask

    task automatic t_ignored_bits();
        load(0, 16'h0005); load(1, 16'h0007);
        set_port_tick(8'h88);
        set_port_tick(8'h00);
        set_port_tick(8'h88);
        check("R5 bits 3 and 7 ignored", cnt_out, 32'h0007_0005);
    endtask

    task automatic t_reset_bit();
        load(0, 16'h1234); load(1, 16'h0000);
        set_port_tick(8'h04);
        check("R6 reset bit clears", cnt_out, 32'h0000_0000);
        set_port_tick(8'h00);
        set_port_tick(8'h07);
        check("R6 reset beats edge", cnt_out, 32'h0000_0000);
        set_port_tick(8'h03);
        check("R6 edge during reset not counted later", cnt_out, 32'h0000_0000);
        set_port_tick(8'h02);
        set_port_tick(8'h03);
        check("R6 counting resumes", cnt_out, 32'h0000_0001);
    endtask

    task automatic t_load();
        load(0, 16'hCAFE);
        load(1, 16'hBEEF);
        check("R7 R8 loads placed in halves", cnt_out, 32'hBEEF_CAFE);
        set_port_tick(8'h22);
        settle(8'h32);
        @(negedge clk);
        tick = 1'b1; ld_en = 1'b1; ld_sel = 1'b1; ld_val = 16'h1000;
        @(negedge clk);
        tick = 1'b0; ld_en = 1'b0;
        check("R7 load beats count", cnt_out, 32'h1000_CAFE);
        pulse_tick();
        check("R7 prev updated on load tick", cnt_out, 32'h1000_CAFE);
    endtask

    task automatic t_sync_latency();
        load(0, 16'h0000); load(1, 16'h0000);
        set_port_tick(8'h02);
        @(negedge clk);
        port_in = 8'h03; tick = 1'b1;
        repeat (2) @(negedge clk);
        tick = 1'b0;
        check("R2 ticks at edges one and two see old value", cnt_out, 32'h0000_0000);
        pulse_tick();
        check("R2 later tick sees new value", cnt_out, 32'h0000_0001);
    endtask

    task automatic t_no_tick();
        load(0, 16'h00AA); load(1, 16'h00BB);
        set_port_tick(8'h22);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            port_in = (k % 2 == 0) ? 8'h33 : 8'h22;
        end
        repeat (4) @(negedge clk);
        check("R9 no change without tick", cnt_out, 32'h00BB_00AA);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count_up();
        t_count_down_wrap();
        t_second_counter();
        t_ignored_bits();
        t_reset_bit();
        t_load();
        t_sync_latency();
        t_no_tick();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule